// File: doc/BRIEF.md
# Fan Tachometer Period Meter

The block times fan tachometer pulses on one of sixteen input channels at a time. Each channel is tied to one of eight PWM ports through a per-channel source field. Each port in turn names one of three clock types, and the clock type supplies the edge polarity, the tick prescaler and the timeout window. Every tach input passes through a two-flop synchronizer before its edges are detected.

Software starts a run by writing the trigger vector to zero and then setting the bit of the wanted channel. The block waits for the first qualifying edge on that channel, counts prescaled ticks up to the next qualifying edge, and posts the count with a done flag in a single 32-bit result word. If the window runs out first, because the fan has stalled, the channel is disabled or the mode is the reserved code, the block posts done with a count of zero. Conversion of the count to RPM is left to software.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset the result word is all zeros.
- R2: A trigger bit that goes from 0 to 1 starts a run on that channel, and the lowest such bit wins when several rise together. Result reads zero from the next cycle until the run ends. A trigger bit held high starts no further run and leaves a posted result unchanged.
- R3: Mode code 00 qualifies falling edges. The count is floor(D/P), where D is the clock-cycle distance between two successive falling edges and P is the tick period.
- R4: Mode code 01 qualifies rising edges, with the same count rule as R3.
- R5: Mode code 10 qualifies both edges, so the count covers the distance between adjacent edges of either polarity, which is half a pulse period for a symmetric input.
- R6: The tick period is 4 << (2*d) clock cycles for the 2-bit divider code d, giving 4, 16, 64 or 256.
- R7: A run that sees no second qualifying edge before the tick count since the trigger reaches the 16-bit window value of its type ends with done set and count 0.
- R8: Mode code 11 qualifies no edge, so such a run always ends as in R7.
- R9: A channel whose enable bit is 0 qualifies no edge and ends as in R7.
- R10: Channel c reads its port number from chan_src[3c+2:3c], and port p reads its type from port_type[2p+1:2p]. Type t reads mode from type_mode[2t+1:2t], divider from type_div[2t+1:2t] and window from type_window[16t+15:16t]. A type code of 3 selects type 0.
- R11: The result word holds done in bit 31 and the count in bits 19:0, and bits 30:20 are always zero. The count is zero whenever done is zero, and a posted result stays fixed until the next run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 16 | Raw tachometer inputs, one per channel |
| chan_en | input | 16 | Per-channel enable |
| chan_src | input | 48 | Per-channel 3-bit PWM port select |
| port_type | input | 16 | Per-port 2-bit clock type select |
| type_mode | input | 6 | Per-type 2-bit edge mode |
| type_div | input | 6 | Per-type 2-bit tick divider code |
| type_window | input | 48 | Per-type 16-bit timeout window in ticks |
| trigger | input | 16 | Trigger vector, one bit per channel |
| result | output | 32 | Done flag and 20-bit count |

## Verification
A wrong channel pick or a wrong selection path through port and type shows at the port as a count of the wrong scale, or as a zero after a timeout where a count was due. It becomes visible as soon as the run posts. A prescaler that is off by one cycle shows only when the edge distance is an exact multiple of the tick period or one cycle short of it, so those boundary distances are measured on purpose. A stuck or mis-sequenced measurement state shows as done never rising within the window, as done dropping without a fresh trigger bit, or as a held result that drifts.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_MEAS = 2'd2
  } meas_state_e;

  localparam int CNT_W    = 20;
  localparam int RES_W    = 32;
  localparam int DONE_BIT = 31;
  localparam int PC_W     = 8;

  // last prescaler value for divider code d: (4 << 2d) - 1
  function automatic logic [PC_W-1:0] div_last(input logic [1:0] d);
    logic [PC_W:0] full;
    logic [PC_W:0] less;
    full = 9'd4 << {d, 1'b0};
    less = full - 9'd1;
    return less[PC_W-1:0];
  endfunction

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin,
  output logic [NUM_CH-1:0] rise,
  output logic [NUM_CH-1:0] fall
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= pin[g];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end

    assign rise[g] = sync_q & ~last_q;
    assign fall[g] = ~sync_q & last_q;
  end

endmodule

// File: rtl/tach_trig_pick.sv
module tach_trig_pick #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] trigger,
  output logic              start,
  output logic [CH_W-1:0]   start_ch
);

  logic [NUM_CH-1:0] trig_q;
  logic [NUM_CH-1:0] fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= trigger;
  end

  assign fresh = trigger & ~trig_q;
  assign start = |fresh;

  always_comb begin
    start_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (fresh[i]) start_ch = i[CH_W-1:0];
    end
  end

endmodule

// File: rtl/tach_cfg_sel.sv
module tach_cfg_sel #(
  parameter int NUM_CH   = 16,
  parameter int NUM_PORT = 8,
  parameter int NUM_TYPE = 3,
  parameter int WIN_W    = 16,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int PSEL_W  = $clog2(NUM_PORT),
  localparam int TSEL_W  = $clog2(NUM_TYPE)
) (
  input  logic [CH_W-1:0]            ch,
  input  logic [NUM_CH-1:0]          chan_en,
  input  logic [NUM_CH*PSEL_W-1:0]   chan_src,
  input  logic [NUM_PORT*TSEL_W-1:0] port_type,
  input  logic [NUM_TYPE*2-1:0]      type_mode,
  input  logic [NUM_TYPE*2-1:0]      type_div,
  input  logic [NUM_TYPE*WIN_W-1:0]  type_window,
  output logic                       sel_en,
  output logic [1:0]                 sel_mode,
  output logic [1:0]                 sel_div,
  output logic [WIN_W-1:0]           sel_win
);

  localparam logic [TSEL_W:0] TYPE_LIMIT = NUM_TYPE[TSEL_W:0];

  logic [PSEL_W-1:0] port;
  logic [TSEL_W-1:0] tsel;
  logic [TSEL_W-1:0] tidx;

  always_comb begin
    port     = chan_src[ch*PSEL_W +: PSEL_W];
    tsel     = port_type[port*TSEL_W +: TSEL_W];
    tidx     = ({1'b0, tsel} < TYPE_LIMIT) ? tsel : '0;
    sel_en   = chan_en[ch];
    sel_mode = type_mode[tidx*2 +: 2];
    sel_div  = type_div[tidx*2 +: 2];
    sel_win  = type_window[tidx*WIN_W +: WIN_W];
  end

endmodule

// File: rtl/tach_engine.sv
module tach_engine
  import fan_tach_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int WIN_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   start_ch,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_div,
  input  logic [WIN_W-1:0]  cfg_win,
  input  logic [NUM_CH-1:0] rise,
  input  logic [NUM_CH-1:0] fall,
  output logic [RES_W-1:0]  result
);

  meas_state_e      state_q, state_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  edge_mode_e       mode_q, mode_d;
  logic             en_q, en_d;
  logic [PC_W-1:0]  last_q, last_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [WIN_W-1:0] wcnt_q, wcnt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RES_W-1:0] res_q, res_d;

  logic             qual, tick, expire;
  logic [WIN_W:0]   wnext;
  logic [RES_W-1:0] done_zero;

  assign done_zero = RES_W'(1) << DONE_BIT;

  always_comb begin
    case (mode_q)
      EDGE_FALL: qual = fall[ch_q];
      EDGE_RISE: qual = rise[ch_q];
      EDGE_BOTH: qual = rise[ch_q] | fall[ch_q];
      default:   qual = 1'b0;
    endcase
    qual   = qual & en_q;
    tick   = (pc_q == last_q);
    wnext  = {1'b0, wcnt_q} + 1'b1;
    expire = tick && ({1'b0, win_q} <= wnext);
  end

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    mode_d  = mode_q;
    en_d    = en_q;
    last_d  = last_q;
    win_d   = win_q;
    pc_d    = pc_q;
    wcnt_d  = wcnt_q;
    cnt_d   = cnt_q;
    res_d   = res_q;
    if (start) begin
      state_d = ST_ARM;
      ch_d    = start_ch;
      mode_d  = edge_mode_e'(cfg_mode);
      en_d    = cfg_en;
      last_d  = div_last(cfg_div);
      win_d   = cfg_win;
      pc_d    = '0;
      wcnt_d  = '0;
      cnt_d   = '0;
      res_d   = '0;
    end else if (state_q != ST_IDLE) begin
      pc_d = tick ? '0 : pc_q + 1'b1;
      if (tick) begin
        wcnt_d = wnext[WIN_W-1:0];
        cnt_d  = cnt_q + 1'b1;
      end
      if (state_q == ST_ARM) begin
        if (qual) begin
          state_d = ST_MEAS;
          pc_d    = '0;
          cnt_d   = '0;
        end else if (expire) begin
          state_d = ST_IDLE;
          res_d   = done_zero;
        end
      end else begin
        if (qual) begin
          state_d = ST_IDLE;
          res_d   = done_zero | RES_W'(cnt_q + CNT_W'(tick));
        end else if (expire) begin
          state_d = ST_IDLE;
          res_d   = done_zero;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      mode_q  <= EDGE_FALL;
      en_q    <= 1'b0;
      last_q  <= '0;
      win_q   <= '0;
      pc_q    <= '0;
      wcnt_q  <= '0;
      cnt_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      mode_q  <= mode_d;
      en_q    <= en_d;
      last_q  <= last_d;
      win_q   <= win_d;
      pc_q    <= pc_d;
      wcnt_q  <= wcnt_d;
      cnt_q   <= cnt_d;
      res_q   <= res_d;
    end
  end

  assign result = res_q;

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import fan_tach_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int NUM_PORT = 8,
  parameter int NUM_TYPE = 3,
  parameter int WIN_W    = 16,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int PSEL_W  = $clog2(NUM_PORT),
  localparam int TSEL_W  = $clog2(NUM_TYPE)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          tach_in,
  input  logic [NUM_CH-1:0]          chan_en,
  input  logic [NUM_CH*PSEL_W-1:0]   chan_src,
  input  logic [NUM_PORT*TSEL_W-1:0] port_type,
  input  logic [NUM_TYPE*2-1:0]      type_mode,
  input  logic [NUM_TYPE*2-1:0]      type_div,
  input  logic [NUM_TYPE*WIN_W-1:0]  type_window,
  input  logic [NUM_CH-1:0]          trigger,
  output logic [RES_W-1:0]           result
);

  logic [NUM_CH-1:0] rise, fall;
  logic              start;
  logic [CH_W-1:0]   start_ch;
  logic              sel_en;
  logic [1:0]        sel_mode, sel_div;
  logic [WIN_W-1:0]  sel_win;

  tach_sync #(.NUM_CH(NUM_CH)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin(tach_in), .rise(rise), .fall(fall)
  );

  tach_trig_pick #(.NUM_CH(NUM_CH)) i_pick (
    .clk(clk), .rst_n(rst_n), .trigger(trigger),
    .start(start), .start_ch(start_ch)
  );

  tach_cfg_sel #(
    .NUM_CH(NUM_CH), .NUM_PORT(NUM_PORT), .NUM_TYPE(NUM_TYPE), .WIN_W(WIN_W)
  ) i_cfg (
    .ch(start_ch), .chan_en(chan_en), .chan_src(chan_src),
    .port_type(port_type), .type_mode(type_mode), .type_div(type_div),
    .type_window(type_window), .sel_en(sel_en), .sel_mode(sel_mode),
    .sel_div(sel_div), .sel_win(sel_win)
  );

  tach_engine #(.NUM_CH(NUM_CH), .WIN_W(WIN_W)) i_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ch(start_ch),
    .cfg_en(sel_en), .cfg_mode(sel_mode), .cfg_div(sel_div),
    .cfg_win(sel_win), .rise(rise), .fall(fall), .result(result)
  );

endmodule

// File: rtl/fan_tach_meter_chk.sv
module fan_tach_meter_chk #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] trigger,
  input logic [31:0]       result
);

  logic [NUM_CH-1:0] trig_prev;
  logic              new_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_prev <= '0;
    else        trig_prev <= trigger;
  end

  assign new_trig = |(trigger & ~trig_prev);

  // R11
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result[30:20] == 11'd0);

  // R11
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result[31] |-> result[19:0] == 20'd0);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_trig |=> result == 32'd0);

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result[31] && !new_trig) |=> $stable(result));

  // R2
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(result[31]) |-> $past(new_trig));

endmodule

bind fan_tach_meter fan_tach_meter_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk(clk), .rst_n(rst_n), .trigger(trigger), .result(result)
);

// File: tb/test_fan_tach_meter.sv
`timescale 1ns/1ps
module test_fan_tach_meter;

  logic        clk;
  logic        rst_n;
  logic [15:0] tach_in;
  logic [15:0] chan_en;
  logic [47:0] chan_src;
  logic [15:0] port_type;
  logic [5:0]  type_mode;
  logic [5:0]  type_div;
  logic [47:0] type_window;
  logic [15:0] trigger;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_mode [3];
  int m_div  [3];
  int m_win  [3];
  int m_pt   [8];

  fan_tach_meter i_fan_tach_meter (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .chan_en(chan_en),
    .chan_src(chan_src), .port_type(port_type), .type_mode(type_mode),
    .type_div(type_div), .type_window(type_window), .trigger(trigger),
    .result(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply_cfg();
    for (int t = 0; t < 3; t++) begin
      type_mode[2*t +: 2]    = 2'(m_mode[t]);
      type_div[2*t +: 2]     = 2'(m_div[t]);
      type_window[16*t +: 16] = 16'(m_win[t]);
    end
    for (int p = 0; p < 8; p++) port_type[2*p +: 2] = 2'(m_pt[p]);
  endtask

  function automatic int ch_type(input int ch);
    int pt;
    pt = m_pt[ch % 8];
    return (pt >= 3) ? 0 : pt;
  endfunction

  function automatic int exp_count(input int ch, input int a, input int b);
    int t, md, per, iv;
    t   = ch_type(ch);
    md  = m_mode[t];
    per = 4 << (2 * m_div[t]);
    if (!chan_en[ch] || md == 3) return 0;
    iv = (md == 2) ? a : a + b;
    return iv / per;
  endfunction

  task automatic run_meas(input string req, input int ch, input int a, input int b,
                          input bit zero_exp, input logic [15:0] extra);
    int md, ex;
    logic idle;
    logic [31:0] got;
    md   = m_mode[ch_type(ch)];
    idle = (md == 0);
    ex   = zero_exp ? 0 : exp_count(ch, a, b);
    tach_in[ch] = idle;
    repeat (6) @(negedge clk);
    trigger = '0;
    @(negedge clk);
    trigger = (16'd1 << ch) | extra;
    @(negedge clk);
    check({req, " R2 cleared"}, result, 32'd0);
    repeat (2) @(negedge clk);
    tach_in[ch] = ~tach_in[ch];
    repeat (a) @(negedge clk);
    tach_in[ch] = ~tach_in[ch];
    repeat (b) @(negedge clk);
    tach_in[ch] = ~tach_in[ch];
    for (int w = 0; w < 20000; w++) begin
      if (result[31]) break;
      @(negedge clk);
    end
    got = result;
    check(req, got, {1'b1, 11'd0, 20'(ex)});
    repeat (40) @(negedge clk);
    check({req, " R2 held trigger"}, result, got);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    tach_in = '0;
    chan_en = 16'hFFFF & ~(16'd1 << 12);
    trigger = '0;
    for (int c = 0; c < 16; c++) chan_src[3*c +: 3] = 3'(c % 8);
    m_mode = '{0, 1, 2};
    m_div  = '{0, 1, 0};
    m_win  = '{1000, 200, 500};
    m_pt   = '{0, 1, 2, 0, 1, 2, 0, 3};
    apply_cfg();
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", result, 32'd0);

    // R3 R4 R5 R10: sweep all enabled channels over their mapped types
    for (int c = 0; c < 16; c++) begin
      if (c != 12) run_meas("R10 sweep R3/R4/R5", c, 10 + 3 * c, 7 + 5 * c, 1'b0, '0);
    end
    // R3 tick boundaries
    run_meas("R3 exact multiple", 0, 20, 20, 1'b0, '0);
    run_meas("R3 one short", 0, 20, 19, 1'b0, '0);
    // R4 boundaries on a rising-edge type
    run_meas("R4 exact multiple", 1, 30, 34, 1'b0, '0);
    run_meas("R4 one short", 4, 30, 33, 1'b0, '0);
    // R5 half interval
    run_meas("R5 both edges", 2, 8, 40, 1'b0, '0);
    run_meas("R5 both one short", 5, 7, 40, 1'b0, '0);
    // R10 type code 3 falls back to type 0
    run_meas("R10 type code 3", 7, 23, 18, 1'b0, '0);
    // R6 divider codes on type 0
    m_div[0] = 1; apply_cfg();
    run_meas("R6 div 16", 0, 50, 33, 1'b0, '0);
    m_div[0] = 2; apply_cfg();
    run_meas("R6 div 64", 3, 150, 70, 1'b0, '0);
    m_div[0] = 3; apply_cfg();
    run_meas("R6 div 256", 6, 400, 200, 1'b0, '0);
    m_div[0] = 0; apply_cfg();
    // R7 window expires before second edge (200 ticks of 16 cycles)
    run_meas("R7 window", 1, 2000, 2000, 1'b1, '0);
    // R7 stalled fan: edges outside window on both-edge type
    run_meas("R7 stall", 2, 2500, 10, 1'b1, '0);
    // R9 disabled channel
    run_meas("R9 disabled", 12, 20, 20, 1'b1, '0);
    // R8 reserved mode
    m_mode[2] = 3; apply_cfg();
    run_meas("R8 reserved mode", 2, 20, 20, 1'b1, '0);
    m_mode[2] = 2; apply_cfg();
    // R2 lowest new bit wins
    run_meas("R2 lowest pick", 3, 25, 25, 1'b0, 16'd1 << 10);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule